// File: doc/BRIEF.md
# FIFO Threshold Service Request Controller

This block decides when a serial controller with one receive byte FIFO and one transmit byte FIFO needs servicing. It takes the current fill level of each FIFO, a programmed threshold for each direction, and a transfer byte count that is loaded at the start of each transfer. From these it raises four status conditions. Receive-ready and transmit-ready cover full threshold-sized bursts. Receive-drain and transmit-drain cover a final partial burst, when the transfer length is not a whole multiple of the threshold.

The conditions are latched into a sticky raw status vector. Software clears a bit by writing 1 to it. The latched bits are masked by an enable vector and merged onto a single interrupt line. Two DMA request lines follow the ready conditions, and each has its own enable. For each direction, the number of bytes still to move is available as an output, so the tail burst can be sized exactly. The FIFO depth is a parameter and can be read back. FIFO storage, clock-domain crossing and the serial engine lie outside the block. Fill levels and byte-moved strobes arrive as inputs.

Top module: `fsc_ctrl`

## Requirements
- R1: `depth_value` always equals the DEPTH parameter, including during and right after reset.
- R2: Status bit 0 (receive-ready) is set when the receive remaining count is at least the effective receive threshold and the receive fill level is at least that threshold.
- R3: Status bit 1 (transmit-ready) is set when the transmit remaining count is at least the effective transmit threshold and the free space (DEPTH minus transmit fill level) is at least that threshold.
- R4: Status bit 2 (receive-drain) is set when the receive remaining count is nonzero, is below the effective receive threshold, and is no larger than the receive fill level. Receive-ready is not raised for that tail.
- R5: Status bit 3 (transmit-drain) is set when the transmit remaining count is nonzero, is below the effective transmit threshold, and is no larger than the transmit free space.
- R6: A threshold of 0 acts as 1, and a threshold above DEPTH acts as DEPTH.
- R7: A start strobe loads the remaining count from `xfer_len`, with start taking priority. Each byte-moved strobe decrements the count by one. The count stops at zero, and no request of that direction is raised while it is zero.
- R8: A status bit that has been set stays set until a 1 is written to the same bit of `clr_mask`. If the condition is still true in that cycle, the set wins.
- R9: `irq` is high exactly when some latched status bit has its enable bit set. It updates on the same clock edge as the status vector.
- R10: Each DMA request is registered from its ready condition ANDed with its DMA enable. It falls on the edge after the condition stops holding, while the latched status bit may stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level | input | LVL_W | Bytes waiting in the receive FIFO |
| tx_level | input | LVL_W | Bytes held in the transmit FIFO |
| rx_thresh | input | LVL_W | Programmed receive threshold |
| tx_thresh | input | LVL_W | Programmed transmit threshold |
| xfer_len | input | CNT_W | Transfer length loaded on a start strobe |
| rx_start | input | 1 | Load the receive remaining count |
| tx_start | input | 1 | Load the transmit remaining count |
| rx_moved | input | 1 | One byte was read out of the receive FIFO |
| tx_moved | input | 1 | One byte was written into the transmit FIFO |
| irq_en | input | 4 | Interrupt enable per status bit |
| clr_mask | input | 4 | Write-one-to-clear strobe per status bit |
| dma_rx_en | input | 1 | Enable for the receive DMA request |
| dma_tx_en | input | 1 | Enable for the transmit DMA request |
| raw_status | output | 4 | Latched status: bit0 rx-ready, bit1 tx-ready, bit2 rx-drain, bit3 tx-drain |
| irq | output | 1 | Merged interrupt |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |
| rx_left | output | CNT_W | Receive bytes still to move |
| tx_left | output | CNT_W | Transmit bytes still to move |
| depth_value | output | LVL_W | FIFO depth readout |

## Verification
The bench builds the block with DEPTH of 8 and CNT_W of 8. At that depth a completely full and a completely empty FIFO are easy to reach, and a threshold of 15 exercises clamping to the depth. Short transfer lengths such as 3, 5 and 6 fall between threshold multiples, so both drain conditions can be tested next to their ready counterparts in one table. Directed sequences then cover counter exhaustion, the set-over-clear collision and DMA release.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int ST_RXR = 0;
  localparam int ST_TXR = 1;
  localparam int ST_RXD = 2;
  localparam int ST_TXD = 3;
  localparam int ST_N   = 4;
  typedef logic [ST_N-1:0] st_vec_t;
endpackage

// File: rtl/fsc_dir.sv
module fsc_dir #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 16,
  parameter bit IS_TX = 1'b0,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  input  logic             moved,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thresh,
  output logic [CNT_W-1:0] left,
  output logic             ready_c,
  output logic             drain_c
);
  logic [LVL_W-1:0] eff_th;
  logic [LVL_W-1:0] avail;
  logic [CNT_W-1:0] th_w;
  logic [CNT_W-1:0] avail_w;

  // R6: clamp threshold into 1..DEPTH
  always_comb begin
    if (thresh == '0)
      eff_th = LVL_W'(1);
    else if (thresh > LVL_W'(DEPTH))
      eff_th = LVL_W'(DEPTH);
    else
      eff_th = thresh;
  end

  generate
    if (IS_TX) begin : g_free
      assign avail = LVL_W'(DEPTH) - level;
    end else begin : g_fill
      assign avail = level;
    end
  endgenerate

  assign th_w    = CNT_W'(eff_th);
  assign avail_w = CNT_W'(avail);

  // R7: remaining byte counter
  always_ff @(posedge clk) begin
    if (rst)
      left <= '0;
    else if (start)
      left <= len;
    else if (moved && left != '0)
      left <= left - CNT_W'(1);
  end

  assign ready_c = (left >= th_w) && (avail_w >= th_w);
  assign drain_c = (left != '0) && (left < th_w) && (avail_w >= left);

  a_r7_load: assert property (@(posedge clk) disable iff (rst)
    start |=> left == $past(len));
  a_r7_dec: assert property (@(posedge clk) disable iff (rst)
    (!start && moved && left != '0) |=> left == $past(left) - CNT_W'(1));
  a_r7_floor: assert property (@(posedge clk) disable iff (rst)
    (!start && left == '0) |=> left == '0);
  a_r7_idle: assert property (@(posedge clk) disable iff (rst)
    (left == '0) |-> !(ready_c || drain_c));
endmodule

// File: rtl/fsc_status.sv
module fsc_status
  import fsc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  st_vec_t set_c,
  input  st_vec_t clr,
  input  st_vec_t en,
  output st_vec_t raw,
  output logic    irq
);
  st_vec_t raw_next;

  // R8: set dominates a simultaneous clear
  assign raw_next = (raw & ~clr) | set_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw <= '0;
      irq <= 1'b0;
    end else begin
      raw <= raw_next;
      irq <= |(raw_next & en);
    end
  end

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw & $past(raw & ~clr)) == $past(raw & ~clr)));
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw & $past(clr & ~set_c)) == '0));
  a_r9_irq: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |(raw & $past(en))));
endmodule

// File: rtl/fsc_ctrl.sv
module fsc_ctrl
  import fsc_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_thresh,
  input  logic [LVL_W-1:0] tx_thresh,
  input  logic [CNT_W-1:0] xfer_len,
  input  logic             rx_start,
  input  logic             tx_start,
  input  logic             rx_moved,
  input  logic             tx_moved,
  input  logic [3:0]       irq_en,
  input  logic [3:0]       clr_mask,
  input  logic             dma_rx_en,
  input  logic             dma_tx_en,
  output logic [3:0]       raw_status,
  output logic             irq,
  output logic             dma_rx_req,
  output logic             dma_tx_req,
  output logic [CNT_W-1:0] rx_left,
  output logic [CNT_W-1:0] tx_left,
  output logic [LVL_W-1:0] depth_value
);
  logic rx_ready_c, rx_drain_c, tx_ready_c, tx_drain_c;
  st_vec_t cond;

  fsc_dir #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_TX(1'b0)) u_rx (
    .clk(clk), .rst(rst), .start(rx_start), .len(xfer_len),
    .moved(rx_moved), .level(rx_level), .thresh(rx_thresh),
    .left(rx_left), .ready_c(rx_ready_c), .drain_c(rx_drain_c)
  );

  fsc_dir #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_TX(1'b1)) u_tx (
    .clk(clk), .rst(rst), .start(tx_start), .len(xfer_len),
    .moved(tx_moved), .level(tx_level), .thresh(tx_thresh),
    .left(tx_left), .ready_c(tx_ready_c), .drain_c(tx_drain_c)
  );

  always_comb begin
    cond         = '0;
    cond[ST_RXR] = rx_ready_c;
    cond[ST_TXR] = tx_ready_c;
    cond[ST_RXD] = rx_drain_c;
    cond[ST_TXD] = tx_drain_c;
  end

  fsc_status u_st (
    .clk(clk), .rst(rst), .set_c(cond), .clr(clr_mask),
    .en(irq_en), .raw(raw_status), .irq(irq)
  );

  // R10: registered DMA requests
  always_ff @(posedge clk) begin
    if (rst) begin
      dma_rx_req <= 1'b0;
      dma_tx_req <= 1'b0;
    end else begin
      dma_rx_req <= dma_rx_en & rx_ready_c;
      dma_tx_req <= dma_tx_en & tx_ready_c;
    end
  end

  assign depth_value = LVL_W'(DEPTH);

  a_r10_rx_flag: assert property (@(posedge clk) disable iff (rst)
    dma_rx_req |-> raw_status[ST_RXR]);
  a_r10_tx_flag: assert property (@(posedge clk) disable iff (rst)
    dma_tx_req |-> raw_status[ST_TXR]);
  a_r10_rx_bound: assert property (@(posedge clk) disable iff (rst)
    dma_rx_req |-> $past(rx_left) != '0);
  a_r4_rx_excl: assert property (@(posedge clk) disable iff (rst)
    rx_drain_c |=> !dma_rx_req);
  a_r1_depth: assert property (@(posedge clk)
    depth_value == LVL_W'(DEPTH));
endmodule

// File: tb/fsc_ctrl_bench.sv
`timescale 1ns/1ps
module fsc_ctrl_bench;
  localparam int DEPTH = 8;
  localparam int CNT_W = 8;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int NV = 9;

  // rxl, txl, rth, tth (4b each), len (8b), raw (4b), dma_rx, dma_tx
  localparam logic [29:0] VEC [NV] = '{
    {4'd4, 4'd0, 4'd4,  4'd4,  8'd10, 4'b0011, 1'b1, 1'b1},
    {4'd3, 4'd5, 4'd4,  4'd4,  8'd10, 4'b0000, 1'b0, 1'b0},
    {4'd2, 4'd6, 4'd4,  4'd4,  8'd3,  4'b0000, 1'b0, 1'b0},
    {4'd3, 4'd5, 4'd4,  4'd4,  8'd3,  4'b1100, 1'b0, 1'b0},
    {4'd1, 4'd7, 4'd0,  4'd0,  8'd5,  4'b0011, 1'b1, 1'b1},
    {4'd8, 4'd0, 4'd15, 4'd15, 8'd20, 4'b0011, 1'b1, 1'b1},
    {4'd7, 4'd1, 4'd15, 4'd15, 8'd20, 4'b0000, 1'b0, 1'b0},
    {4'd8, 4'd0, 4'd2,  4'd2,  8'd0,  4'b0000, 1'b0, 1'b0},
    {4'd5, 4'd0, 4'd4,  4'd6,  8'd5,  4'b1001, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst;
  logic [LVL_W-1:0] rx_level, tx_level, rx_thresh, tx_thresh;
  logic [CNT_W-1:0] xfer_len;
  logic rx_start, tx_start, rx_moved, tx_moved;
  logic [3:0] irq_en, clr_mask;
  logic dma_rx_en, dma_tx_en;
  logic [3:0] raw_status;
  logic irq, dma_rx_req, dma_tx_req;
  logic [CNT_W-1:0] rx_left, tx_left;
  logic [LVL_W-1:0] depth_value;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  fsc_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fsc_ctrl (
    .clk(clk), .rst(rst), .rx_level(rx_level), .tx_level(tx_level),
    .rx_thresh(rx_thresh), .tx_thresh(tx_thresh), .xfer_len(xfer_len),
    .rx_start(rx_start), .tx_start(tx_start), .rx_moved(rx_moved),
    .tx_moved(tx_moved), .irq_en(irq_en), .clr_mask(clr_mask),
    .dma_rx_en(dma_rx_en), .dma_tx_en(dma_tx_en), .raw_status(raw_status),
    .irq(irq), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req),
    .rx_left(rx_left), .tx_left(tx_left), .depth_value(depth_value)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; rx_level = '0; tx_level = '0; rx_thresh = '0; tx_thresh = '0;
    xfer_len = '0; rx_start = 0; tx_start = 0; rx_moved = 0; tx_moved = 0;
    irq_en = '0; clr_mask = '0; dma_rx_en = 0; dma_tx_en = 0;
    tick(); tick();
    // R1 and reset state
    chk("R1 depth", 32'(depth_value), 32'(DEPTH));
    rst = 1'b0;
    tick();
    chk("R8 reset raw", 32'(raw_status), 0);
    chk("R9 reset irq", 32'(irq), 0);
    chk("R10 reset dma", 32'({dma_rx_req, dma_tx_req}), 0);
    chk("R7 reset left", 32'({rx_left, tx_left}), 0);
    chk("R1 depth after reset", 32'(depth_value), 32'(DEPTH));

    // Vector table: R2 R3 R4 R5 R6 R7
    irq_en = 4'hF; dma_rx_en = 1; dma_tx_en = 1;
    for (int i = 0; i < NV; i++) begin
      rst = 1'b1;
      tick();
      rst = 1'b0;
      rx_level  = VEC[i][29:26];
      tx_level  = VEC[i][25:22];
      rx_thresh = VEC[i][21:18];
      tx_thresh = VEC[i][17:14];
      xfer_len  = VEC[i][13:6];
      rx_start = 1; tx_start = 1;
      tick();
      rx_start = 0; tx_start = 0;
      tick();
      chk($sformatf("R2/R3/R4/R5/R6 vec%0d raw", i), 32'(raw_status), 32'(VEC[i][5:2]));
      chk($sformatf("R10 vec%0d dma_rx", i), 32'(dma_rx_req), 32'(VEC[i][1]));
      chk($sformatf("R10 vec%0d dma_tx", i), 32'(dma_tx_req), 32'(VEC[i][0]));
      chk($sformatf("R9 vec%0d irq", i), 32'(irq), 32'(VEC[i][5:2] != 4'b0));
    end

    // Directed: latch, clear, mask, DMA release
    rst = 1'b1; irq_en = '0; dma_tx_en = 0;
    tick();
    rst = 1'b0;
    rx_level = 4; rx_thresh = 4; tx_level = 8; tx_thresh = 4; xfer_len = 10;
    rx_start = 1; tx_start = 1;
    tick();
    rx_start = 0; tx_start = 0;
    tick();
    chk("R2 directed raw", 32'(raw_status), 32'h1);
    chk("R9 masked irq", 32'(irq), 0);
    chk("R10 dma_rx high", 32'(dma_rx_req), 1);
    rx_level = 0;
    tick();
    chk("R10 dma_rx released", 32'(dma_rx_req), 0);
    chk("R8 latched after cond gone", 32'(raw_status), 32'h1);
    irq_en = 4'h1;
    tick();
    chk("R9 enabled irq", 32'(irq), 1);
    clr_mask = 4'h1;
    tick();
    clr_mask = 4'h0;
    chk("R8 w1c clears", 32'(raw_status), 0);
    chk("R9 irq drops with clear", 32'(irq), 0);
    rx_level = 4;
    tick();
    clr_mask = 4'h1;
    tick();
    clr_mask = 4'h0;
    chk("R8 set wins over clear", 32'(raw_status), 32'h1);
    dma_rx_en = 0;
    tick();
    chk("R10 dma disabled", 32'(dma_rx_req), 0);

    // R7 counter
    rx_moved = 1;
    tick();
    rx_moved = 0;
    chk("R7 decrement", 32'(rx_left), 9);
    xfer_len = 2; rx_start = 1; rx_moved = 1;
    tick();
    rx_start = 0;
    chk("R7 start priority", 32'(rx_left), 2);
    tick();
    chk("R7 dec to 1", 32'(rx_left), 1);
    tick();
    chk("R7 dec to 0", 32'(rx_left), 0);
    tick();
    rx_moved = 0;
    chk("R7 floor at 0", 32'(rx_left), 0);
    rx_level = 8; clr_mask = 4'hF;
    tick();
    clr_mask = 4'h0;
    tick();
    chk("R7 no rx request at zero", 32'(raw_status & 4'b0101), 0);

    finish_run();
  end
endmodule